// File: doc/BRIEF.md
# Write-Only Two-Wire Configuration Receiver

This block is a receive-only slave on a two-wire open-drain bus. It loads a bank of configuration bits that sit directly on its output port. The bus master opens a transfer with a start condition and sends a byte that holds a 7-bit device address and a direction bit. After that it sends data bits. Each data bit lands in the next configuration bit as soon as it is complete. No byte-wide holding register is used, so the outputs change bit by bit while the transfer runs.

The block drives the data line only to acknowledge a byte. It does this by asserting an open-drain enable, and the pad then pulls the line low. A transfer may end after any bit, either with a stop condition or with a new start. Bits that the transfer did not reach keep their values. Both bus lines are sampled by the system clock through synchronisers. The system clock must run at least eight times faster than the bus clock.

Top module: `cfg_serial_slave`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `cfg_bits` is all zero and `sda_oe` is 0.
- R2: A falling data line while the clock is high is a start condition. A rising data line while the clock is high is a stop condition. A data bit is the data level sampled at the clock's rising edge. That bit is taken only when the clock then falls without a start or stop in between.
- R3: After a start, the first byte is taken MSB first. Its upper 7 bits must equal `DEV_ADDR` and its last bit must be 0, meaning write. If so, the block asserts `sda_oe` for the ninth clock period.
- R4: If the first byte does not match as in R3, no acknowledge is given and no bit of `cfg_bits` changes until the next start condition.
- R5: Data bit k after the address byte (k counted from 0) is written to `cfg_bits[k]`. The write takes effect within 4 system clocks of the bus clock falling edge that ends that bit. No other bit changes.
- R6: After every 8 data bits, `sda_oe` is asserted within 4 system clocks of the falling edge that ends the eighth bit. It is released within 4 system clocks of the falling edge that ends the ninth clock period.
- R7: A stop condition ends a transfer at any bit position. A bit whose clock rose but did not fall before the stop is not written. Bits not reached keep their values.
- R8: A repeated start restarts the address phase and resets the write position to bit 0.
- R9: Data bits past position `NUM_BITS`-1 are acknowledged per byte and then discarded.
- R10: `sda_oe` changes only while the synchronised bus clock is low. It is never asserted except in an acknowledge slot.
- R11: Bus activity that is not preceded by a start condition writes nothing and is never acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level, as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls the data line low |
| cfg_bits | output | NUM_BITS | Live configuration bits |

## Verification
A bus line change needs two synchroniser flops and one edge-compare cycle before the block sees it. The register update then takes one more edge. So a completed bit reaches `cfg_bits` on the third system clock after the bus clock falls, and `sda_oe` moves on that same edge. The bench holds every bus phase for at least four system clocks and checks each written bit four clocks after the fall. It checks the acknowledge state eight clocks after the fall that starts the slot, and checks the release six clocks after the fall that ends it. The reference register image is kept in the bench from the bit position and address match, and is compared after every bit.

// File: rtl/cfgsl_pkg.sv
package cfgsl_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ACK,
        PH_DATA
    } phase_e;

    typedef struct packed {
        logic scl_lvl;
        logic sda_lvl;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    localparam int BYTE_BITS = 8;

    // Address byte: device address in the upper seven bits, write flag (0) last.
    function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
        return (b[7:1] == dev) && !b[0];
    endfunction

endpackage

// File: rtl/cfgsl_sync.sv
module cfgsl_sync
    import cfgsl_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_d;
    logic              sda_d;

    // Idle bus reads high, so reset to 1 to avoid false edges.
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_d <= scl_q[STAGES-1];
            sda_d <= sda_q[STAGES-1];
        end
    end

    always_comb begin
        ev.scl_lvl  = scl_q[STAGES-1];
        ev.sda_lvl  = sda_q[STAGES-1];
        ev.scl_rise = ev.scl_lvl && !scl_d;
        ev.scl_fall = !ev.scl_lvl && scl_d;
        ev.start    = ev.scl_lvl && scl_d && sda_d && !ev.sda_lvl;
        ev.stop     = ev.scl_lvl && scl_d && !sda_d && ev.sda_lvl;
    end

endmodule

// File: rtl/cfgsl_engine.sv
module cfgsl_engine
    import cfgsl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2C,
    parameter int         NUM_BITS = 32,
    parameter int         PW       = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_ev_t       ev,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [PW-1:0] wr_idx,
    output logic          wr_val
);

    phase_e        phase;
    logic          smp;
    logic          pend;
    logic          ack_hi;
    logic [7:0]    shreg;
    logic [3:0]    bcnt;
    logic [PW-1:0] ptr;
    logic [7:0]    byte_next;
    logic          in_range;
    logic          bit_done;

    always_comb begin
        byte_next = {shreg[6:0], smp};
        in_range  = ptr < PW'(NUM_BITS);
        bit_done  = ev.scl_fall && pend;
        wr_en     = (phase == PH_DATA) && bit_done && in_range;
        wr_idx    = ptr;
        wr_val    = smp;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            smp    <= 1'b0;
            pend   <= 1'b0;
            ack_hi <= 1'b0;
            shreg  <= '0;
            bcnt   <= '0;
            ptr    <= '0;
            sda_oe <= 1'b0;
        end else if (ev.start) begin
            phase  <= PH_ADDR;
            pend   <= 1'b0;
            ack_hi <= 1'b0;
            bcnt   <= '0;
            ptr    <= '0;
            sda_oe <= 1'b0;
        end else if (ev.stop) begin
            phase  <= PH_IDLE;
            pend   <= 1'b0;
            ack_hi <= 1'b0;
            sda_oe <= 1'b0;
        end else begin
            case (phase)
                PH_ADDR, PH_DATA: begin
                    if (ev.scl_rise) begin
                        smp  <= ev.sda_lvl;
                        pend <= 1'b1;
                    end else if (bit_done) begin
                        pend  <= 1'b0;
                        shreg <= byte_next;
                        bcnt  <= bcnt + 4'd1;
                        if (phase == PH_DATA && in_range)
                            ptr <= ptr + PW'(1);
                        if (bcnt == 4'(BYTE_BITS - 1)) begin
                            bcnt <= '0;
                            if (phase == PH_DATA || addr_hit(byte_next, DEV_ADDR)) begin
                                sda_oe <= 1'b1;
                                phase  <= PH_ACK;
                            end else begin
                                phase  <= PH_IDLE;
                            end
                        end
                    end
                end
                PH_ACK: begin
                    if (ev.scl_rise) begin
                        ack_hi <= 1'b1;
                    end else if (ev.scl_fall && ack_hi) begin
                        ack_hi <= 1'b0;
                        sda_oe <= 1'b0;
                        phase  <= PH_DATA;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cfgsl_regbank.sv
module cfgsl_regbank #(
    parameter int NUM_BITS = 32,
    parameter int PW       = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [PW-1:0]       wr_idx,
    input  logic                wr_val,
    output logic [NUM_BITS-1:0] bits
);

    for (genvar g = 0; g < NUM_BITS; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                bits[g] <= 1'b0;
            else if (wr_en && wr_idx == PW'(g))
                bits[g] <= wr_val;
        end
    end

endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
    import cfgsl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h2C,
    parameter int         NUM_BITS    = 32,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe,
    output logic [NUM_BITS-1:0] cfg_bits
);

    localparam int PW = $clog2(NUM_BITS + 1);

    bus_ev_t       ev;
    logic          wr_en;
    logic [PW-1:0] wr_idx;
    logic          wr_val;
    logic          scl_lvl;
    logic          ev_start;
    logic          ev_stop;

    assign scl_lvl  = ev.scl_lvl;
    assign ev_start = ev.start;
    assign ev_stop  = ev.stop;

    cfgsl_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    cfgsl_engine #(.DEV_ADDR(DEV_ADDR), .NUM_BITS(NUM_BITS), .PW(PW)) eng_i (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .sda_oe (sda_oe),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_val (wr_val)
    );

    cfgsl_regbank #(.NUM_BITS(NUM_BITS), .PW(PW)) bank_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_val (wr_val),
        .bits   (cfg_bits)
    );

endmodule

// File: rtl/cfgsl_checker.sv
module cfgsl_checker #(
    parameter int NUM_BITS = 32,
    parameter int PW       = 6
) (
    input logic                clk,
    input logic                rst,
    input logic                scl_lvl,
    input logic                ev_start,
    input logic                ev_stop,
    input logic                sda_oe,
    input logic                wr_en,
    input logic [PW-1:0]       wr_idx,
    input logic [NUM_BITS-1:0] cfg_bits
);

    p_quiet_bank_r5: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg_bits));

    p_single_bit_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> $countones(cfg_bits ^ $past(cfg_bits)) <= 1);

    p_index_range_r9: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_idx < PW'(NUM_BITS)));

    p_oe_clock_low_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_lvl);

    p_stop_release_r7: assert property (@(posedge clk) disable iff (rst)
        ev_stop |=> !sda_oe);

    p_start_restart_r8: assert property (@(posedge clk) disable iff (rst)
        ev_start |=> (!sda_oe && !wr_en));

    p_no_write_in_ack_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !sda_oe);

endmodule

bind cfg_serial_slave cfgsl_checker #(.NUM_BITS(NUM_BITS), .PW(PW)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .scl_lvl  (scl_lvl),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .sda_oe   (sda_oe),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .cfg_bits (cfg_bits)
);

// File: tb/cfg_serial_slave_tb_top.sv
`timescale 1ns/1ps
module cfg_serial_slave_tb_top;

    localparam logic [6:0] ADDR = 7'h5A;
    localparam int         NB   = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          m_scl = 1'b1;
    logic          m_sda = 1'b1;
    logic          sda_oe;
    logic [NB-1:0] cfg_bits;
    logic          sda_pin;
    logic [NB-1:0] exp_bits = '0;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    assign sda_pin = m_sda & ~sda_oe;

    always #2.5 clk = ~clk;

    cfg_serial_slave #(.DEV_ADDR(ADDR), .NUM_BITS(NB), .SYNC_STAGES(2)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (m_scl),
        .sda_i    (sda_pin),
        .sda_oe   (sda_oe),
        .cfg_bits (cfg_bits)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(4);
        m_scl = 1'b1; tick(8);
        m_sda = 1'b0; tick(8);
        m_scl = 1'b0; tick(4);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(4);
        m_scl = 1'b1; tick(8);
        m_sda = 1'b1; tick(8);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b;    tick(4);
        m_scl = 1'b1; tick(8);
        m_scl = 1'b0; tick(4);
    endtask

    task automatic ack_slot(input bit exp_ack, input string req);
        m_sda = 1'b1; tick(4);
        chk(sda_oe == exp_ack, req, 32'(sda_oe), 32'(exp_ack));
        m_scl = 1'b1; tick(4);
        chk(sda_pin == !exp_ack, req, 32'(sda_pin), 32'(!exp_ack));
        tick(4);
        m_scl = 1'b0; tick(6);
        chk(sda_oe == 1'b0, "R6", 32'(sda_oe), 32'd0);
    endtask

    task automatic xfer(input logic [6:0] a, input logic rw, input int nbits,
                        input logic [31:0] data, input bit do_stop, input string tag);
        bit hit;
        hit = (a == ADDR) && (rw == 1'b0);
        bus_start();
        for (int i = 6; i >= 0; i--) send_bit(a[i]);
        send_bit(rw);
        ack_slot(hit, hit ? "R3" : "R4");
        for (int i = 0; i < nbits; i++) begin
            send_bit(data[i]);
            if (hit && i < NB) exp_bits[i] = data[i];
            chk(cfg_bits == exp_bits, (i >= NB) ? "R9" : tag, 32'(cfg_bits), 32'(exp_bits));
            if (i % 8 == 7) ack_slot(hit, hit ? "R6" : "R4");
        end
        if (do_stop) begin
            bus_stop();
            chk(cfg_bits == exp_bits, "R7", 32'(cfg_bits), 32'(exp_bits));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        tick(3);
        chk(cfg_bits == '0, "R1", 32'(cfg_bits), 32'd0);
        chk(sda_oe == 1'b0, "R1", 32'(sda_oe), 32'd0);
        rst = 1'b0;
        tick(1);
        chk(cfg_bits == '0 && sda_oe == 1'b0, "R1", 32'(cfg_bits), 32'd0);

        // R11: clocked bits with no start condition
        m_scl = 1'b0; tick(4);
        for (int i = 0; i < 18; i++) begin
            send_bit(1'(i % 3 != 0));
            chk(sda_oe == 1'b0 && cfg_bits == '0, "R11", 32'(cfg_bits), 32'd0);
        end

        // R5/R9: full write plus four extra bits that are discarded
        xfer(ADDR, 1'b0, 16, 32'h0000_A5C3, 1'b1, "R5");

        // R4: address mismatch, then wrong direction bit
        xfer(ADDR ^ 7'h01, 1'b0, 16, 32'h0000_FFFF, 1'b1, "R4");
        xfer(ADDR ^ 7'h40, 1'b0, 9, 32'h0000_0000, 1'b1, "R4");
        xfer(ADDR, 1'b1, 16, 32'h0000_0F0F, 1'b1, "R3");

        // R7: truncated after five bits (R2 stop detection)
        xfer(ADDR, 1'b0, 5, 32'h0000_001A, 1'b1, "R7");
        chk(cfg_bits == exp_bits, "R2", 32'(cfg_bits), 32'(exp_bits));

        // R8: repeated start restarts at bit 0 (R2 start detection)
        xfer(ADDR, 1'b0, 3, 32'h0000_0007, 1'b0, "R8");
        xfer(ADDR, 1'b0, 4, 32'h0000_0000, 1'b1, "R8");
        chk(cfg_bits[3:0] == 4'h0, "R2", 32'(cfg_bits), 32'(exp_bits));

        // Sweep of data patterns, with a length that varies
        for (int p = 0; p < 16; p++) begin
            xfer(ADDR, 1'b0, 8 + (p % 9), 32'((p * 1093 + 5) ^ (p << 7)), 1'b1, "R5");
        end

        done = 1'b1;
        summary();
    end

endmodule